// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block is the digital front end of an 8-bit voltage-output converter. A parallel data bus loads a first-stage holding register, and a second-stage output register supplies the code that the converter core turns into a voltage. Four active-low control pins decide what happens: a select, a write strobe, a transfer strobe and a clear. Both stages behave as level-sensitive latches that share the write strobe. Because the second stage can be loaded on its own, several instances that share one transfer line can change their outputs together.

The pins are asynchronous to the system clock. The block samples them through two-flop synchronizers and models the latch behaviour in the clock domain. A stage follows its source while it is open, and it keeps the last value it followed once the write strobe returns high. The clear pin has two effects. When both stages are open, it forces the code to zero only while the pin is low. When both stages are closed, it leaves zeros stored after the pin is released. The block also gives the ideal output value, code × reference / 2^width, and a one-cycle strobe each time the output code changes.

Top module: `dac_dbuf_if`

## Requirements
- R1: After system reset the output code is 0, the ideal value is 0 and the update strobe is low, before any write.
- R2: The holding register follows the bus while select and write are both low. It keeps the bus value that was present when write rose, and later bus changes have no effect.
- R3: The output register follows the holding register while transfer and write are both low. The holding register's contents then appear on the output code.
- R4: While write is high, neither register changes, whatever the levels on select, transfer and the bus.
- R5: With select and write low and transfer high, only the holding register follows the bus, and the output code keeps its value.
- R6: A low level on the clear pin loads zeros into both registers, whatever the other controls are doing.
- R7: With both registers open, the clear pin forces the output code to zero only while the pin is low. After the pin is released, the code follows the bus again.
- R8: With both registers closed, a clear pulse leaves zeros in both registers. The code stays 0 after the pulse, and a later transfer without a new write also gives 0.
- R9: The ideal output equals floor(code × REF_VAL / 256). Full scale (code 255) gives 255/256 of the reference, and code 0 gives 0.
- R10: The update strobe is high for exactly one cycle for each change of the output code and is low otherwise. Instances that share the transfer line change their codes and raise their strobes in the same cycle.
- R11: A pin level sampled at a rising edge k reaches the holding register at edge k+2 and the output register at edge k+3. The code, the strobe and the ideal value match this timing on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Synchronous active-low system reset |
| sel_n | input | 1 | Select pin, active low |
| wr_n | input | 1 | Write strobe pin, active low |
| xfer_n | input | 1 | Transfer-to-output pin, active low |
| clr_n | input | 1 | Clear / zero-override pin, active low |
| bus_d | input | DATA_W | Parallel data bus |
| dac_code | output | DATA_W | Output register contents driven to the converter core |
| code_upd | output | 1 | One-cycle strobe when dac_code changes |
| ideal_val | output | IDEAL_W | Ideal output value in reference units |

## Verification
The stimulus opens the stages in every combination: only the first stage, only the second, both together and neither. Each pattern separates capture at the write edge from continued following of the bus. A clear pulse is applied once with both stages open and once with both closed, which separates the temporary override from stored zeros. Two instances share the transfer line but are loaded with different data, so a common transfer tells shared-line simultaneous update apart from per-instance loading. Full-scale and zero codes fix the end points of the ideal value.

// File: rtl/dac_dbuf_pkg.sv
// Shared types for the double-buffered converter code register.
// Assumes: all control pins are active low; idle means every pin high.
package dac_dbuf_pkg;
    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic xfer_n;
        logic clr_n;
    } dac_pins_t;

    localparam dac_pins_t PINS_IDLE = '{sel_n: 1'b1, wr_n: 1'b1, xfer_n: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/dac_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes: the bits of the vector are stable around the edges where they are used
// together (data setup/hold around write), so they are sampled as a group.
module dac_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two sampling stages, reset to the idle pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dac_latch_stage.sv
// One register stage modelled as a level latch in the clock domain.
// While open it follows its source; once closed it keeps the last value it followed,
// so the value present when write rises is the one held. Clear wins over everything.
// Assumes: open and clr_n are already synchronized.
module dac_latch_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         open,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Follow when open, hold when closed, zero on clear or system reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !clr_n) q <= '0;
        else if (open)        q <= d;
    end
endmodule

// File: rtl/dac_ideal.sv
// Ideal converter output: floor(code * REF_VAL / 2^W).
// Assumes: REF_VAL fits in IDEAL_W bits; the result is then always below REF_VAL.
module dac_ideal #(
    parameter int W       = 8,
    parameter int IDEAL_W = 32,
    parameter int REF_VAL = 10_000_000
) (
    input  logic [W-1:0]       code,
    output logic [IDEAL_W-1:0] val
);
    localparam int PROD_W = W + IDEAL_W;
    logic [PROD_W-1:0] prod;

    // Scale the code by the reference and drop the fractional bits.
    always_comb begin
        prod = PROD_W'(code) * PROD_W'(REF_VAL);
        val  = IDEAL_W'(prod >> W);
    end
endmodule

// File: rtl/dac_dbuf_if.sv
// Double-buffered converter code register (top).
// Pins are oversampled through two-flop synchronizers. The holding stage opens on
// select+write low, the output stage on transfer+write low, and both clear on clr_n low.
// code_upd pulses for one cycle whenever dac_code changes.
// Assumes: the clock period is short enough to see every pin pulse, and bus data
// is held at least until the synchronized write edge has been sampled.
module dac_dbuf_if #(
    parameter int DATA_W  = 8,
    parameter int IDEAL_W = 32,
    parameter int REF_VAL = 10_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               wr_n,
    input  logic               xfer_n,
    input  logic               clr_n,
    input  logic [DATA_W-1:0]  bus_d,
    output logic [DATA_W-1:0]  dac_code,
    output logic               code_upd,
    output logic [IDEAL_W-1:0] ideal_val
);
    import dac_dbuf_pkg::*;

    localparam int PIN_W = $bits(dac_pins_t);
    localparam int ALL_W = PIN_W + DATA_W;

    dac_pins_t          pins_s;
    logic [DATA_W-1:0]  bus_s;
    logic [ALL_W-1:0]   raw_all;
    logic [ALL_W-1:0]   sync_all;
    logic               sel_s, wr_s, xfer_s, clr_s;
    logic               hold_open, out_open;
    logic [DATA_W-1:0]  hold_q;
    logic [DATA_W-1:0]  out_q;
    logic [DATA_W-1:0]  out_prev;

    // Pins and data share one synchronizer so their relative timing is kept.
    assign raw_all = {sel_n, wr_n, xfer_n, clr_n, bus_d};

    dac_sync #(
        .W       (ALL_W),
        .RST_VAL ({PINS_IDLE, {DATA_W{1'b0}}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_all),
        .q     (sync_all)
    );

    // Split the synchronized vector back into pins and data.
    always_comb begin
        pins_s    = dac_pins_t'(sync_all[ALL_W-1 -: PIN_W]);
        bus_s     = sync_all[DATA_W-1:0];
        sel_s     = pins_s.sel_n;
        wr_s      = pins_s.wr_n;
        xfer_s    = pins_s.xfer_n;
        clr_s     = pins_s.clr_n;
        hold_open = !sel_s  && !wr_s;
        out_open  = !xfer_s && !wr_s;
    end

    dac_latch_stage #(.W(DATA_W)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_s),
        .open  (hold_open),
        .d     (bus_s),
        .q     (hold_q)
    );

    dac_latch_stage #(.W(DATA_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_s),
        .open  (out_open),
        .d     (hold_q),
        .q     (out_q)
    );

    // Remember the previous output code to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) out_prev <= '0;
        else        out_prev <= out_q;
    end

    assign dac_code = out_q;
    assign code_upd = (out_q != out_prev);

    dac_ideal #(
        .W       (DATA_W),
        .IDEAL_W (IDEAL_W),
        .REF_VAL (REF_VAL)
    ) u_ideal (
        .code (out_q),
        .val  (ideal_val)
    );
endmodule

// File: rtl/dac_dbuf_chk.sv
// Property checker for dac_dbuf_if, attached with bind below.
// Assumes: synchronized pin levels are brought in by name from the top.
module dac_dbuf_chk #(
    parameter int DATA_W  = 8,
    parameter int IDEAL_W = 32,
    parameter int REF_VAL = 10_000_000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_s,
    input logic               xfer_s,
    input logic               clr_s,
    input logic               out_open,
    input logic [DATA_W-1:0]  hold_q,
    input logic [DATA_W-1:0]  dac_code,
    input logic               code_upd,
    input logic [IDEAL_W-1:0] ideal_val
);
    // R4: write high and no clear keeps the output code.
    assert_wr_high_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_s && clr_s) |=> $stable(dac_code));

    // R5: transfer high and no clear keeps the output code.
    assert_xfer_high_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_s && clr_s) |=> $stable(dac_code));

    // R6: clear low gives a zero code on the next cycle.
    assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (dac_code == '0));

    // R10: an open output stage seeing different holding data raises the strobe.
    assert_strobe_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_open && clr_s && (hold_q != dac_code)) |=> code_upd);

    // R9: end points of the ideal value.
    assert_ideal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == '0) |-> (ideal_val == '0));

    assert_ideal_below_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code == '1) |-> (ideal_val < IDEAL_W'(REF_VAL)));
endmodule

bind dac_dbuf_if dac_dbuf_chk #(
    .DATA_W  (DATA_W),
    .IDEAL_W (IDEAL_W),
    .REF_VAL (REF_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_s      (wr_s),
    .xfer_s    (xfer_s),
    .clr_s     (clr_s),
    .out_open  (out_open),
    .hold_q    (hold_q),
    .dac_code  (dac_code),
    .code_upd  (code_upd),
    .ideal_val (ideal_val)
);

// File: tb/dac_dbuf_if_test.sv
// Bench: two instances share write, transfer, clear and bus, with separate selects.
// A behavioural cycle model (two-deep sample queue per instance) is compared every clock.
module dac_dbuf_if_test;
    localparam int  REF = 10_000_000;
    localparam time HALF = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sel_n = 2'b11;
    logic       wr_n = 1'b1, xfer_n = 1'b1, clr_n = 1'b1;
    logic [7:0] bus_d = 8'h00;
    logic [7:0] code [2];
    logic       upd  [2];
    logic [31:0] ideal [2];

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    always #HALF clk = ~clk;

    dac_dbuf_if uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n[0]), .wr_n(wr_n), .xfer_n(xfer_n),
        .clr_n(clr_n), .bus_d(bus_d), .dac_code(code[0]), .code_upd(upd[0]),
        .ideal_val(ideal[0]));

    dac_dbuf_if uut2 (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n[1]), .wr_n(wr_n), .xfer_n(xfer_n),
        .clr_n(clr_n), .bus_d(bus_d), .dac_code(code[1]), .code_upd(upd[1]),
        .ideal_val(ideal[1]));

    // Reference model state: queued samples {sel,wr,xfer,clr,data} and two registers.
    int q_smp [2][$];
    int m_hold [2];
    int m_out  [2];
    int m_upd  [2];

    task automatic check(string tag, longint act, longint exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update at each rising edge, from pin levels driven at the falling edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!rst_n) begin
                q_smp[i] = {32'h0F00, 32'h0F00};
                m_hold[i] = 0; m_out[i] = 0; m_upd[i] = 0;
            end else begin
                int s, sel, wr, xf, cl, dat, nh, no;
                s   = q_smp[i].pop_front();
                sel = (s >> 11) & 1; wr = (s >> 10) & 1;
                xf  = (s >> 9) & 1;  cl = (s >> 8) & 1; dat = s & 255;
                nh = m_hold[i]; no = m_out[i];
                if (cl == 0) begin nh = 0; no = 0; end
                else begin
                    if (sel == 0 && wr == 0) nh = dat;
                    if (xf == 0 && wr == 0)  no = m_hold[i];
                end
                m_upd[i] = (no != m_out[i]);
                m_hold[i] = nh; m_out[i] = no;
                q_smp[i].push_back({sel_n[i], wr_n, xfer_n, clr_n, bus_d});
            end
        end
    end

    // R11: compare outputs with the cycle model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < 2; i++) begin
                check("R11 code", code[i], m_out[i]);
                check("R11 strobe", upd[i], m_upd[i]);
                check("R11 ideal", ideal[i], (longint'(m_out[i]) * REF) >> 8);
            end
        end
    end

    task automatic pins(input logic [1:0] s, input logic w, input logic x,
                        input logic c, input logic [7:0] d);
        @(negedge clk);
        sel_n = s; wr_n = w; xfer_n = x; clr_n = c; bus_d = d;
    endtask

    task automatic wait_cyc(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100_000 && !done) begin
            done = 1;
            mismatched++; compared++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int n0, n1, diff;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 code", code[0], 0);
        check("R1 strobe", upd[0], 0);
        check("R1 ideal", ideal[0], 0);

        // R5: only the holding stage opens; the code must not move.
        pins(2'b10, 0, 1, 1, 8'h5A); wait_cyc(6);
        check("R5 code kept", code[0], 0);
        pins(2'b10, 1, 1, 1, 8'h5A); wait_cyc(2);
        // R2: bus changes after write rose are ignored.
        pins(2'b10, 1, 1, 1, 8'h33); wait_cyc(2);
        pins(2'b11, 1, 1, 1, 8'h33); wait_cyc(2);
        // R3: transfer only; output takes the held 0x5A.
        pins(2'b11, 0, 0, 1, 8'h33); wait_cyc(6);
        check("R2 held value", code[0], 8'h5A);
        check("R3 transfer", code[1], 0);
        pins(2'b11, 1, 1, 1, 8'h33); wait_cyc(2);

        // R4: write high with everything else active changes nothing.
        pins(2'b10, 1, 0, 1, 8'hC3); wait_cyc(6);
        check("R4 code kept", code[0], 8'h5A);

        // R7: both open, clear pulse is a temporary override.
        pins(2'b10, 0, 0, 1, 8'h81); wait_cyc(6);
        check("R3 both open", code[0], 8'h81);
        pins(2'b10, 0, 0, 0, 8'h81); wait_cyc(6);
        check("R6 override", code[0], 0);
        pins(2'b10, 0, 0, 1, 8'h81); wait_cyc(6);
        check("R7 restored", code[0], 8'h81);
        pins(2'b11, 1, 1, 1, 8'h81); wait_cyc(3);

        // R8: both closed, clear stores zeros that persist.
        pins(2'b11, 1, 1, 0, 8'h81); wait_cyc(4);
        pins(2'b11, 1, 1, 1, 8'h81); wait_cyc(6);
        check("R8 zero kept", code[0], 0);
        pins(2'b11, 0, 0, 1, 8'h81); wait_cyc(6);
        check("R8 holding zero", code[0], 0);
        pins(2'b11, 1, 1, 1, 8'h81); wait_cyc(2);

        // R9: full scale.
        pins(2'b10, 0, 0, 1, 8'hFF); wait_cyc(6);
        check("R9 full scale", ideal[0], (longint'(255) * REF) / 256);
        pins(2'b11, 1, 1, 1, 8'hFF); wait_cyc(2);

        // R10: load different values, then one shared transfer.
        pins(2'b10, 0, 1, 1, 8'h11); wait_cyc(4);
        pins(2'b10, 1, 1, 1, 8'h11); wait_cyc(2);
        pins(2'b01, 0, 1, 1, 8'h22); wait_cyc(4);
        pins(2'b01, 1, 1, 1, 8'h22); wait_cyc(2);
        pins(2'b11, 1, 1, 1, 8'h22); wait_cyc(3);
        check("R10 no early change", code[0], 8'hFF);
        pins(2'b11, 0, 0, 1, 8'h22);
        n0 = 0; n1 = 0; diff = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            n0 += upd[0]; n1 += upd[1];
            if (upd[0] != upd[1]) diff++;
        end
        check("R10 strobes together", diff, 0);
        check("R10 one pulse uut", n0, 1);
        check("R10 one pulse uut2", n1, 1);
        check("R10 code uut", code[0], 8'h11);
        check("R10 code uut2", code[1], 8'h22);
        pins(2'b11, 1, 1, 1, 8'h00); wait_cyc(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule